// File: doc/BRIEF.md
# Frame Accept/Reject Window Arbiter

This block takes the final keep-or-drop decision for every frame the receiver sees. External address-filter logic may pull an active-low reject line to veto a frame. The block accepts that veto only if the line stays low for a minimum time, measured in system-clock cycles, and only inside a window. The window opens at the start-of-frame delimiter and stays open for a fixed number of bit times. The internal address-match result, a promiscuous switch, a runt-accept switch and a strict mode override or reshape that window. In strict mode the unicast physical filter is disabled and the logical filter is all zero.

When a frame ends, the block raises exactly one of two registered one-cycle pulses: accept or discard. All frame state is cleared at the next delimiter. The block works whenever the engine-run input is high. This holds even when software has the receive and transmit paths turned off, so external logic can still watch the traffic. The frame data path, the DMA and the address filters themselves live elsewhere.

Top module: `frame_reject_arbiter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `accept_o` and `discard_o` are low.
- R2: An `eof_i` pulse during an open frame gives exactly one of `accept_o`/`discard_o`, high for one cycle, in the cycle after `eof_i`. An `eof_i` with no open frame gives neither.
- R3: A reject counts only after `ext_rej_n` has been sampled low on MIN_CLKS consecutive clock edges. MIN_CLKS = ceil(MIN_NS*CLK_MHZ/1000), which is 50 by default. A low pulse one cycle shorter has no effect.
- R4: A qualified reject is honoured only while fewer than WIN_BITS (default 512) `bit_tick_i` pulses have been counted since `sof_i`. A reject that qualifies later is ignored, and the frame is accepted.
- R5: If `int_match_i` is high in any cycle of the frame after `sof_i`, and strict mode is off, the frame is accepted even when a reject was honoured.
- R6: With `promisc_i` high, a frame of at least WIN_BITS bit ticks is accepted whatever the reject and match inputs do.
- R7: With `runt_ok_i` low, a frame that ends with fewer than WIN_BITS bit ticks is discarded, even in promiscuous mode. With `runt_ok_i` high, a short frame is decided by the normal rules, and a reject is honoured up to its end.
- R8: With `strict_i` high, `int_match_i` is ignored. A frame is accepted if and only if no reject was honoured (promiscuous mode and the runt rule still apply).
- R9: While `run_en_i` is low, no decision pulse is produced and `sof_i` is ignored. A frame that is open when `run_en_i` falls is abandoned without a decision.
- R10: A new `sof_i` clears any honoured reject and match from an earlier frame, including a frame that never saw `eof_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en_i | input | 1 | Engine running; block is idle while low |
| promisc_i | input | 1 | Promiscuous mode: accept every full frame |
| runt_ok_i | input | 1 | Runt accept: keep frames shorter than the window |
| strict_i | input | 1 | Physical filter off and logical filter zero: ignore internal match |
| int_match_i | input | 1 | Internal physical/logical address match |
| ext_rej_n | input | 1 | Active-low reject from external address logic |
| sof_i | input | 1 | One-cycle start-of-frame delimiter event |
| bit_tick_i | input | 1 | One-cycle pulse per received bit time |
| eof_i | input | 1 | One-cycle end-of-frame event |
| accept_o | output | 1 | One-cycle pulse: keep the frame |
| discard_o | output | 1 | One-cycle pulse: drop the frame |

## Verification
The assertions take it as given that `sof_i`, `eof_i` and `bit_tick_i` are single-cycle events. They also assume that `sof_i` and `eof_i` never arrive in the same cycle, and that mode bits hold steady while a frame is open. The stimulus keeps to this: mode bits change only between frames, every event is driven for one cycle at the falling edge, and no bit tick is sent in the delimiter or end-of-frame cycle. Reject pulses are timed against a known bit count, so the window edge and the pulse-width threshold can each be hit exactly on either side.

// File: rtl/frame_reject_pkg.sv
package frame_reject_pkg;

  typedef struct packed {
    logic promisc;
    logic runt_ok;
    logic strict;
  } mode_t;

  typedef enum logic [1:0] {
    VERDICT_NONE    = 2'b00,
    VERDICT_ACCEPT  = 2'b01,
    VERDICT_DISCARD = 2'b10
  } verdict_t;

  function automatic verdict_t decide(input mode_t mode, input logic full_len,
                                      input logic rejected, input logic matched);
    if (!mode.runt_ok && !full_len) return VERDICT_DISCARD;
    if (mode.promisc)               return VERDICT_ACCEPT;
    if (matched && !mode.strict)    return VERDICT_ACCEPT;
    if (rejected)                   return VERDICT_DISCARD;
    return VERDICT_ACCEPT;
  endfunction

endpackage

// File: rtl/rej_pulse_qualifier.sv
module rej_pulse_qualifier #(
  parameter int MIN_CLKS = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic rej_n,
  output logic qualified
);
  localparam int CW = $clog2(MIN_CLKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_CLKS);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || !enable || rej_n) begin
      low_cnt <= '0;
    end else if (low_cnt != LIMIT) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign qualified = (low_cnt == LIMIT);
endmodule

// File: rtl/frame_window_timer.sv
module frame_window_timer #(
  parameter int WIN_BITS = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic sof,
  input  logic eof,
  input  logic tick,
  output logic in_frame,
  output logic win_open,
  output logic full_len
);
  localparam int BW = $clog2(WIN_BITS + 1);
  localparam logic [BW-1:0] LAST = BW'(WIN_BITS);

  logic [BW-1:0] bit_cnt;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      in_frame <= 1'b0;
      bit_cnt  <= '0;
    end else if (sof) begin
      in_frame <= 1'b1;
      bit_cnt  <= '0;
    end else if (eof) begin
      in_frame <= 1'b0;
    end else if (in_frame && tick && bit_cnt != LAST) begin
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign full_len = (bit_cnt == LAST);
  assign win_open = in_frame && !full_len;
endmodule

// File: rtl/frame_reject_arbiter.sv
module frame_reject_arbiter
  import frame_reject_pkg::*;
#(
  parameter int CLK_MHZ  = 250,
  parameter int MIN_NS   = 200,
  parameter int WIN_BITS = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic run_en_i,
  input  logic promisc_i,
  input  logic runt_ok_i,
  input  logic strict_i,
  input  logic int_match_i,
  input  logic ext_rej_n,
  input  logic sof_i,
  input  logic bit_tick_i,
  input  logic eof_i,
  output logic accept_o,
  output logic discard_o
);
  localparam int MIN_CLKS = (MIN_NS * CLK_MHZ + 999) / 1000;

  logic     qual, in_frame, win_open, full_len;
  logic     rej_q, hit_q, rej_now, hit_now;
  mode_t    mode;
  verdict_t verdict;

  rej_pulse_qualifier #(.MIN_CLKS(MIN_CLKS)) u_qual (
    .clk(clk), .rst(rst), .enable(run_en_i), .rej_n(ext_rej_n), .qualified(qual)
  );

  frame_window_timer #(.WIN_BITS(WIN_BITS)) u_win (
    .clk(clk), .rst(rst), .enable(run_en_i), .sof(sof_i), .eof(eof_i),
    .tick(bit_tick_i), .in_frame(in_frame), .win_open(win_open), .full_len(full_len)
  );

  assign mode    = '{promisc: promisc_i, runt_ok: runt_ok_i, strict: strict_i};
  assign rej_now = rej_q || (qual && win_open);
  assign hit_now = hit_q || int_match_i;
  assign verdict = decide(mode, full_len, rej_now, hit_now);

  always_ff @(posedge clk) begin
    if (rst || !run_en_i) begin
      rej_q     <= 1'b0;
      hit_q     <= 1'b0;
      accept_o  <= 1'b0;
      discard_o <= 1'b0;
    end else begin
      accept_o  <= 1'b0;
      discard_o <= 1'b0;
      if (eof_i && in_frame) begin
        accept_o  <= (verdict == VERDICT_ACCEPT);
        discard_o <= (verdict == VERDICT_DISCARD);
      end
      if (sof_i) begin
        rej_q <= 1'b0;
        hit_q <= 1'b0;
      end else if (in_frame) begin
        rej_q <= rej_now;
        hit_q <= hit_now;
      end
    end
  end
endmodule

// File: rtl/frame_reject_checker.sv
module frame_reject_checker (
  input logic clk,
  input logic rst,
  input logic run_en_i,
  input logic promisc_i,
  input logic runt_ok_i,
  input logic ext_rej_n,
  input logic eof_i,
  input logic in_frame,
  input logic full_len,
  input logic qual,
  input logic accept_o,
  input logic discard_o
);
  // R2: never both verdicts at once
  p_one_verdict_r2: assert property (@(posedge clk) disable iff (rst)
    !(accept_o && discard_o));

  // R2: a verdict only follows an end of frame during an open frame
  p_after_eof_r2: assert property (@(posedge clk) disable iff (rst)
    (accept_o || discard_o) |-> $past(eof_i && in_frame && run_en_i));

  // R9: engine stopped means no verdict next cycle
  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !run_en_i |=> !(accept_o || discard_o));

  // R6: promiscuous full-length frame is accepted
  p_promisc_r6: assert property (@(posedge clk) disable iff (rst)
    (run_en_i && eof_i && in_frame && promisc_i && full_len) |=> accept_o);

  // R7: short frame without runt accept is dropped
  p_runt_r7: assert property (@(posedge clk) disable iff (rst)
    (run_en_i && eof_i && in_frame && !runt_ok_i && !full_len) |=> discard_o);

  // R3: a qualified reject needs the line low on the previous edge
  p_qual_low_r3: assert property (@(posedge clk) disable iff (rst)
    qual |-> $past(!ext_rej_n));
endmodule

bind frame_reject_arbiter frame_reject_checker u_chk (
  .clk(clk), .rst(rst), .run_en_i(run_en_i), .promisc_i(promisc_i),
  .runt_ok_i(runt_ok_i), .ext_rej_n(ext_rej_n), .eof_i(eof_i),
  .in_frame(in_frame), .full_len(full_len), .qual(qual),
  .accept_o(accept_o), .discard_o(discard_o)
);

// File: tb/test_frame_reject_arbiter.sv
module test_frame_reject_arbiter;
  localparam int WIN = 512;
  localparam int MINC = 50;

  logic clk = 1'b0, rst = 1'b1;
  logic run_en = 1'b0, promisc = 1'b0, runt_ok = 1'b0, strict = 1'b0;
  logic match = 1'b0, rej_n = 1'b1, sof = 1'b0, tick = 1'b0, eof = 1'b0;
  logic acc, dis;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  frame_reject_arbiter i_frame_reject_arbiter (
    .clk(clk), .rst(rst), .run_en_i(run_en), .promisc_i(promisc),
    .runt_ok_i(runt_ok), .strict_i(strict), .int_match_i(match),
    .ext_rej_n(rej_n), .sof_i(sof), .bit_tick_i(tick), .eof_i(eof),
    .accept_o(acc), .discard_o(dis)
  );

  task automatic chk(input string req, input logic ea, input logic ed);
    tests++;
    if (acc !== ea || dis !== ed) begin
      fails++;
      $display("FAIL %s: accept/discard = %b%b, expected %b%b", req, acc, dis, ea, ed);
    end
  endtask

  task automatic start_frame();
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
  endtask

  task automatic body(input int pre, input int rw, input int post);
    for (int i = 0; i < pre; i++) begin @(negedge clk); tick = 1'b1; end
    for (int i = 0; i < rw; i++) begin @(negedge clk); tick = 1'b0; rej_n = 1'b0; end
    for (int i = 0; i < post; i++) begin @(negedge clk); tick = 1'b1; rej_n = 1'b1; end
    @(negedge clk); tick = 1'b0; rej_n = 1'b1;
  endtask

  task automatic end_frame(input string req, input logic ea, input logic ed);
    eof = 1'b1;
    @(negedge clk); eof = 1'b0; match = 1'b0;
    chk(req, ea, ed);
    @(negedge clk);
    chk({req, " pulse"}, 1'b0, 1'b0);
  endtask

  task automatic frame(input string req, input int pre, input int rw, input int post,
                       input logic m, input logic ed);
    start_frame();
    match = m;
    body(pre, rw, post);
    end_frame(req, !ed, ed);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", 1'b0, 1'b0);
    rst = 1'b0; run_en = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 1'b0, 1'b0);

    // Sweep R5 R6 R7 R8: modes x match x reject x length
    for (int c = 0; c < 64; c++) begin
      logic p, ro, st, m, rj, lg, ed;
      p = c[0]; ro = c[1]; st = c[2]; m = c[3]; rj = c[4]; lg = c[5];
      promisc = p; runt_ok = ro; strict = st;
      if (!ro && !lg)       ed = 1'b1;
      else if (p)           ed = 1'b0;
      else if (m && !st)    ed = 1'b0;
      else                  ed = rj;
      frame("R5/R6/R7/R8 sweep", 40, rj ? 60 : 0, lg ? 560 : 60, m, ed);
    end

    promisc = 0; runt_ok = 1; strict = 0;
    // R3 pulse width threshold
    frame("R3 short pulse ignored", 40, MINC - 1, 560, 1'b0, 1'b0);
    frame("R3 minimum pulse honoured", 40, MINC, 560, 1'b0, 1'b1);
    // R4 window edge
    frame("R4 last bit in window", WIN - 1, MINC, 10, 1'b0, 1'b1);
    frame("R4 window closed", WIN, MINC, 10, 1'b0, 1'b0);
    // R7 runt with reject at very end
    frame("R7 runt reject before end", 30, MINC, 0, 1'b0, 1'b1);
    runt_ok = 0;
    frame("R7 exactly window length kept", WIN, 0, 0, 1'b0, 1'b0);
    frame("R7 one bit short dropped", WIN - 1, 0, 0, 1'b0, 1'b1);

    // R10 stale reject cleared by new delimiter
    start_frame();
    body(20, 60, 10);
    start_frame();
    body(600, 0, 0);
    end_frame("R10 new delimiter clears reject", 1'b1, 1'b0);

    // R2 end of frame with no open frame
    @(negedge clk); eof = 1'b1;
    @(negedge clk); eof = 1'b0;
    chk("R2 eof without frame", 1'b0, 1'b0);

    // R9 engine stopped
    run_en = 0;
    start_frame();
    body(600, 0, 0);
    end_frame("R9 stopped engine silent", 1'b0, 1'b0);
    run_en = 1;
    start_frame();
    body(300, 0, 0);
    run_en = 0;
    @(negedge clk); run_en = 1;
    body(300, 0, 0);
    end_frame("R9 abandoned frame silent", 1'b0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule